// File: doc/BRIEF.md
# Trace FIFO Overflow-Avoidance Controller

This block is a byte-wide trace buffer that protects itself from overflow in one of two ways. Trace packets of one to four bytes arrive on the push side and leave one byte per cycle on the pop side. A 32-bit level register holds a threshold counted in free bytes. In stall mode the block asks the producer to hold off once free space falls below that threshold. In suppress mode it drops, whole and at once, any incoming packet that would push free space below the threshold, and it reports each drop with a one-cycle pulse so that a marker can be emitted further on.

The stall request is gated by a region-enable input, but suppression is not. Writes above the buffer capacity are clamped to the capacity. A build-time option makes the block ignore the register, so that it always behaves as if the threshold were the capacity. An illegal mode setting, or a zero threshold with a mode selected, falls back to no avoidance and raises a flag. With no avoidance, a packet that does not fit is dropped and a sticky overflow flag is set.

Top module: `trace_fifo_guard`

## Requirements
- R1: `cfg_rdata` returns the stored threshold in bits [7:0] and zero in bits [31:8].
- R2: A write whose 32-bit value is greater than the capacity `DEPTH` (this includes any value with a bit set in [31:8]) stores `DEPTH`.
- R3: When `mode_stall`=1 and `mode_suppress`=0, `stall_req` is 1 exactly when `region_en`=1 and the free byte count (`DEPTH` minus the bytes held) is strictly less than the threshold.
- R4: With the threshold equal to `DEPTH` in stall mode, `stall_req` is high whenever the buffer holds at least one byte.
- R5: `region_en`=0 forces `stall_req` low. Suppression works the same whatever `region_en` is, and `stall_req` stays low in suppress mode.
- R6: When `mode_suppress`=1 and `mode_stall`=0, a push whose length n satisfies free - n < threshold is dropped with no byte stored, and `suppress_pulse` is high for exactly the one cycle after that push edge.
- R7: With both mode inputs at 0, `stall_req` stays low and no packet is suppressed.
- R8: `cfg_err` is 1 when both mode inputs are 1, or when either one is 1 and the threshold is 0. The block then behaves as in R7.
- R9: Packet bytes are stored lowest byte first. `push_len` encodes n-1, so code 0 means 1 byte and code 3 means 4 bytes. `pop_valid` is 1 while the buffer is not empty, and each cycle with `pop_ready`=1 removes one byte in arrival order.
- R10: A push that does not fit in the free space and is not suppressed is dropped whole and sets `overflow`. The flag stays set until any register write.
- R11: With `IGNORE_LEVEL`=1, register writes have no effect, reads return `DEPTH`, and the threshold acts as `DEPTH`.
- R12: After reset the buffer is empty, the threshold is `DEPTH`, and `overflow`, `suppress_pulse` and `cfg_err` (with the modes off) are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| push_valid | input | 1 | Packet offered this cycle |
| push_len | input | 2 | Packet length minus one |
| push_data | input | 32 | Packet bytes, first byte in [7:0] |
| pop_ready | input | 1 | Consumer takes one byte |
| pop_valid | output | 1 | Buffer holds a byte |
| pop_data | output | 8 | Oldest byte |
| cfg_wr | input | 1 | Level register write strobe |
| cfg_wdata | input | 32 | Level register write value |
| cfg_rdata | output | 32 | Level register readback |
| mode_stall | input | 1 | Select stall avoidance |
| mode_suppress | input | 1 | Select packet suppression |
| region_en | input | 1 | Qualifies the stall request |
| stall_req | output | 1 | Ask producer to stall |
| suppress_pulse | output | 1 | A packet was just suppressed |
| cfg_err | output | 1 | Illegal avoidance setting |
| overflow | output | 1 | Sticky: packet lost for lack of room |

## Verification
The threshold comparison is tried with fill levels on both sides of the programmed level. The case where free space equals the level separates a strict compare from an inclusive one. A level of capacity with one byte held shows the non-empty rule, and a clamped oversized write shows that clamping reaches the comparator. Region-low and zero-level rows tell the gating and the error fallback apart from a plain miss. Directed runs fill the buffer in suppress mode, where only the breaching packet may vanish, and in no-avoidance mode, where only the overflow flag may react. Multi-byte packets are drained to confirm byte order, and a second instance built to ignore the register is compared against the first.

// File: rtl/tfg_pkg.sv
// Shared types for the trace FIFO guard.
// Assumes: nothing beyond a standard compile order (this file first).
package tfg_pkg;
    // Decoded overflow-avoidance policy.
    typedef enum logic [1:0] {
        AVOID_NONE     = 2'd0,
        AVOID_STALL    = 2'd1,
        AVOID_SUPPRESS = 2'd2
    } avoid_mode_t;

    localparam int unsigned MAX_PKT = 4;
endpackage

// File: rtl/tfg_level_reg.sv
// Threshold register: clamps writes to the capacity and gives a zero-padded readback.
// Assumes: DEPTH in 1..255; IGNORE_LEVEL=1 ties the threshold to DEPTH.
module tfg_level_reg #(
    parameter int unsigned DEPTH        = 16,
    parameter bit          IGNORE_LEVEL = 1'b0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [31:0] wr_val,
    output logic [7:0]  level,
    output logic [31:0] rd_val
);
    localparam logic [7:0]  CAP   = 8'(DEPTH);
    localparam logic [31:0] CAP32 = 32'(DEPTH);

    generate
        if (IGNORE_LEVEL) begin : g_fixed
            // Threshold pinned to capacity; writes discarded.
            assign level = CAP;
        end else begin : g_prog
            logic [7:0] level_q;
            // Store the write value, clamped to capacity.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    level_q <= CAP;
                else if (wr_en)
                    level_q <= (wr_val > CAP32) ? CAP : wr_val[7:0];
            end
            assign level = level_q;

            // R2
            level_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
                level_q <= CAP);
        end
    endgenerate

    // Readback with reserved bits forced to zero.
    assign rd_val = {24'd0, level};
endmodule

// File: rtl/tfg_fifo.sv
// Byte FIFO: writes 1..4 bytes per cycle, reads one byte per cycle.
// Assumes: caller only writes when the packet fits and only reads when non-empty.
module tfg_fifo #(
    parameter int unsigned DEPTH = 16
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  logic [2:0]                     wr_n,
    input  logic [31:0]                    wr_data,
    input  logic                           rd_en,
    output logic [$clog2(DEPTH+1)-1:0]     used,
    output logic                           rd_valid,
    output logic [7:0]                     rd_data
);
    localparam int unsigned CW = $clog2(DEPTH + 1);
    localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [7:0]    mem [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] used_q;

    // Advance an index by a step with wrap-around at DEPTH.
    function automatic logic [PW-1:0] wrap_add(input logic [PW-1:0] base, input int unsigned step);
        int unsigned s;
        s = int'(base) + step;
        if (s >= DEPTH) s = s - DEPTH;
        return PW'(s);
    endfunction

    // Store up to four packet bytes in consecutive slots.
    always_ff @(posedge clk) begin
        for (int unsigned k = 0; k < tfg_pkg::MAX_PKT; k++) begin
            if (wr_en && (k < int'(wr_n)))
                mem[wrap_add(wr_ptr, k)] <= wr_data[8*k +: 8];
        end
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            used_q <= '0;
        end else begin
            if (wr_en) wr_ptr <= wrap_add(wr_ptr, int'(wr_n));
            if (rd_en) rd_ptr <= wrap_add(rd_ptr, 1);
            used_q <= used_q + (wr_en ? CW'(wr_n) : CW'(0)) - (rd_en ? CW'(1) : CW'(0));
        end
    end

    assign used     = used_q;
    assign rd_valid = (used_q != '0);
    assign rd_data  = mem[rd_ptr];

    // R10
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        used_q <= CW'(DEPTH));
endmodule

// File: rtl/tfg_guard.sv
// Avoidance policy: decodes mode, compares free space to the threshold,
// decides stall, suppression and whether a packet fits.
// Assumes: used <= DEPTH, push_n in 1..4.
module tfg_guard #(
    parameter int unsigned DEPTH = 16
) (
    input  logic                       mode_stall,
    input  logic                       mode_suppress,
    input  logic                       region_en,
    input  logic [7:0]                 level,
    input  logic [$clog2(DEPTH+1)-1:0] used,
    input  logic                       push_valid,
    input  logic [2:0]                 push_n,
    output logic                       stall_req,
    output logic                       suppress_hit,
    output logic                       room_ok,
    output logic                       cfg_err
);
    import tfg_pkg::*;

    avoid_mode_t mode;
    logic [8:0]  free_b;
    logic [8:0]  need_b;

    // Resolve the mode inputs; illegal settings fall back to no avoidance.
    always_comb begin
        cfg_err = (mode_stall && mode_suppress) ||
                  ((mode_stall || mode_suppress) && (level == 8'd0));
        if (cfg_err)            mode = AVOID_NONE;
        else if (mode_stall)    mode = AVOID_STALL;
        else if (mode_suppress) mode = AVOID_SUPPRESS;
        else                    mode = AVOID_NONE;
    end

    // Free space and the space a packet needs to keep the threshold.
    always_comb begin
        free_b = 9'(DEPTH) - 9'(used);
        need_b = 9'(push_n) + 9'(level);
    end

    // Stall, suppression and fit decisions.
    always_comb begin
        stall_req    = (mode == AVOID_STALL) && region_en && (free_b < 9'(level));
        suppress_hit = push_valid && (mode == AVOID_SUPPRESS) && (free_b < need_b);
        room_ok      = (9'(push_n) <= free_b);
    end
endmodule

// File: rtl/trace_fifo_guard.sv
// Top: trace byte FIFO with a programmable free-space threshold, stall request,
// atomic packet suppression and a sticky overflow flag.
// Assumes: DEPTH in 4..255; synchronous active-low reset.
module trace_fifo_guard #(
    parameter int unsigned DEPTH        = 16,
    parameter bit          IGNORE_LEVEL = 1'b0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        push_valid,
    input  logic [1:0]  push_len,
    input  logic [31:0] push_data,
    input  logic        pop_ready,
    output logic        pop_valid,
    output logic [7:0]  pop_data,
    input  logic        cfg_wr,
    input  logic [31:0] cfg_wdata,
    output logic [31:0] cfg_rdata,
    input  logic        mode_stall,
    input  logic        mode_suppress,
    input  logic        region_en,
    output logic        stall_req,
    output logic        suppress_pulse,
    output logic        cfg_err,
    output logic        overflow
);
    localparam int unsigned CW = $clog2(DEPTH + 1);

    logic [7:0]    level;
    logic [CW-1:0] used;
    logic [2:0]    push_n;
    logic          suppress_hit, room_ok, accept, lost, rd_en;
    logic          pulse_q, ovf_q;

    assign push_n = 3'(push_len) + 3'd1;

    tfg_level_reg #(.DEPTH(DEPTH), .IGNORE_LEVEL(IGNORE_LEVEL)) u_level (
        .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr), .wr_val(cfg_wdata),
        .level(level), .rd_val(cfg_rdata)
    );

    tfg_guard #(.DEPTH(DEPTH)) u_guard (
        .mode_stall(mode_stall), .mode_suppress(mode_suppress), .region_en(region_en),
        .level(level), .used(used), .push_valid(push_valid), .push_n(push_n),
        .stall_req(stall_req), .suppress_hit(suppress_hit), .room_ok(room_ok),
        .cfg_err(cfg_err)
    );

    // Accept a packet only if it is neither suppressed nor too large.
    always_comb begin
        accept = push_valid && !suppress_hit && room_ok;
        lost   = push_valid && !suppress_hit && !room_ok;
        rd_en  = pop_ready && pop_valid;
    end

    tfg_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .wr_en(accept), .wr_n(push_n), .wr_data(push_data),
        .rd_en(rd_en), .used(used), .rd_valid(pop_valid), .rd_data(pop_data)
    );

    // One-cycle suppression pulse and sticky overflow flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pulse_q <= 1'b0;
            ovf_q   <= 1'b0;
        end else begin
            pulse_q <= suppress_hit;
            if (lost)        ovf_q <= 1'b1;
            else if (cfg_wr) ovf_q <= 1'b0;
        end
    end

    assign suppress_pulse = pulse_q;
    assign overflow       = ovf_q;

    // R6
    suppress_atomic_chk: assert property (@(posedge clk) disable iff (!rst_n)
        suppress_hit |=> (used == $past(used) - ($past(rd_en) ? CW'(1) : CW'(0))));
    // R6
    pulse_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        suppress_pulse |-> $past(mode_suppress && push_valid));
    // R5
    stall_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall_req |-> (region_en && !mode_suppress));
    // R4
    stall_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall_req |-> pop_valid);
    // R8
    cfg_err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> !stall_req);
endmodule

// File: tb/trace_fifo_guard_tb.sv
module trace_fifo_guard_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 16;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        push_valid;
    logic [1:0]  push_len;
    logic [31:0] push_data;
    logic        pop_ready;
    logic        pop_valid, pop_valid_i;
    logic [7:0]  pop_data, pop_data_i;
    logic        cfg_wr;
    logic [31:0] cfg_wdata;
    logic [31:0] cfg_rdata, cfg_rdata_i;
    logic        mode_stall, mode_suppress, region_en;
    logic        stall_req, stall_req_i;
    logic        suppress_pulse, suppress_pulse_i;
    logic        cfg_err, cfg_err_i;
    logic        overflow, overflow_i;

    int n_chk  = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    trace_fifo_guard #(.DEPTH(DEPTH), .IGNORE_LEVEL(1'b0)) u_dut (
        .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_len(push_len),
        .push_data(push_data), .pop_ready(pop_ready), .pop_valid(pop_valid),
        .pop_data(pop_data), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .mode_stall(mode_stall), .mode_suppress(mode_suppress),
        .region_en(region_en), .stall_req(stall_req), .suppress_pulse(suppress_pulse),
        .cfg_err(cfg_err), .overflow(overflow)
    );

    trace_fifo_guard #(.DEPTH(DEPTH), .IGNORE_LEVEL(1'b1)) u_dut_ign (
        .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_len(push_len),
        .push_data(push_data), .pop_ready(pop_ready), .pop_valid(pop_valid_i),
        .pop_data(pop_data_i), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata_i), .mode_stall(mode_stall), .mode_suppress(mode_suppress),
        .region_en(region_en), .stall_req(stall_req_i), .suppress_pulse(suppress_pulse_i),
        .cfg_err(cfg_err_i), .overflow(overflow_i)
    );

    // Table row: {level[31:0], fill[7:0], region, expected stall, expected cfg_err}
    localparam int NROW = 8;
    localparam logic [42:0] ROWS [NROW] = '{
        {32'd4,   8'd12, 1'b1, 1'b0, 1'b0},  // R3 free == level: no stall
        {32'd4,   8'd13, 1'b1, 1'b1, 1'b0},  // R3 free < level
        {32'd16,  8'd1,  1'b1, 1'b1, 1'b0},  // R4 level = capacity, one byte
        {32'd16,  8'd0,  1'b1, 1'b0, 1'b0},  // R4 empty
        {32'd4,   8'd13, 1'b0, 1'b0, 1'b0},  // R5 region low
        {32'd200, 8'd1,  1'b1, 1'b1, 1'b0},  // R2 clamped write acts as capacity
        {32'd0,   8'd16, 1'b1, 1'b0, 1'b1},  // R8 zero level with stall mode
        {32'd8,   8'd9,  1'b1, 1'b1, 1'b0}   // R3 free 7 < 8
    };

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; push_valid = 0; push_len = 0; push_data = 0; pop_ready = 0;
        cfg_wr = 0; cfg_wdata = 0; mode_stall = 0; mode_suppress = 0; region_en = 0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic push(input logic [31:0] d, input logic [1:0] l);
        @(negedge clk);
        push_valid = 1'b1; push_data = d; push_len = l;
        @(negedge clk);
        push_valid = 1'b0;
        #1;
    endtask

    task automatic wr_level(input logic [31:0] v);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_wdata = v;
        @(negedge clk);
        cfg_wr = 1'b0;
        #1;
    endtask

    task automatic pop(output logic [7:0] b);
        @(negedge clk);
        pop_ready = 1'b1;
        #1 b = pop_data;
        @(negedge clk);
        pop_ready = 1'b0;
        #1;
    endtask

    task automatic drain(output int cnt);
        logic [7:0] b;
        cnt = 0;
        while (pop_valid && cnt < 64) begin
            pop(b);
            cnt++;
        end
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 100000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        logic [7:0] b;
        int cnt;
        rst_n = 1'b0;

        // Reset state (R12, R1, R11)
        do_reset();
        #1;
        chk(cfg_rdata == 32'd16, "R12 reset level", cfg_rdata, 32'd16);
        chk(!pop_valid && !overflow && !suppress_pulse && !cfg_err && !stall_req,
            "R12 reset flags", {pop_valid, overflow, suppress_pulse, cfg_err, stall_req}, 0);
        chk(cfg_rdata_i == 32'd16, "R11 ignore read", cfg_rdata_i, 32'd16);

        // Register readback and clamping (R1, R2, R11)
        wr_level(32'd7);
        chk(cfg_rdata == 32'd7, "R1 readback", cfg_rdata, 32'd7);
        chk(cfg_rdata_i == 32'd16, "R11 write ignored", cfg_rdata_i, 32'd16);
        wr_level(32'hFFFF_FFFF);
        chk(cfg_rdata == 32'd16, "R2 clamp all-ones", cfg_rdata, 32'd16);
        wr_level(32'h0000_0103);
        chk(cfg_rdata == 32'd16, "R2 clamp upper bits", cfg_rdata, 32'd16);

        // Table walk: stall threshold comparison
        for (int i = 0; i < NROW; i++) begin
            do_reset();
            mode_stall = 1'b1;
            wr_level(ROWS[i][42:11]);
            for (int f = 0; f < int'(ROWS[i][10:3]); f++) push(32'h0000_00A0 + f, 2'd0);
            region_en = ROWS[i][2];
            #1;
            chk(stall_req == ROWS[i][1], $sformatf("R3 row %0d stall", i), stall_req, ROWS[i][1]);
            chk(cfg_err == ROWS[i][0], $sformatf("R8 row %0d cfg_err", i), cfg_err, ROWS[i][0]);
        end

        // Byte order (R9)
        do_reset();
        push(32'h4433_2211, 2'd3);
        push(32'h0000_6655, 2'd1);
        for (int k = 0; k < 6; k++) begin
            pop(b);
            chk(b == 8'(8'h11 * (k + 1)), "R9 byte order", b, 8'(8'h11 * (k + 1)));
        end
        chk(!pop_valid, "R9 empty after drain", pop_valid, 0);

        // Suppression (R6, R5)
        do_reset();
        mode_suppress = 1'b1;
        region_en = 1'b0;
        wr_level(32'd4);
        push(32'h0403_0201, 2'd3);
        push(32'h0807_0605, 2'd3);
        push(32'h0C0B_0A09, 2'd3);
        chk(!suppress_pulse, "R6 no pulse at free == level", suppress_pulse, 0);
        push(32'h0000_00EE, 2'd0);
        chk(suppress_pulse, "R6 pulse after breach", suppress_pulse, 1);
        @(negedge clk); #1;
        chk(!suppress_pulse, "R6 pulse one cycle", suppress_pulse, 0);
        region_en = 1'b1; #1;
        chk(!stall_req, "R5 no stall in suppress mode", stall_req, 0);
        push(32'h0000_00EF, 2'd0);
        chk(suppress_pulse, "R5 suppression with region high", suppress_pulse, 1);
        chk(!overflow, "R6 no overflow on suppress", overflow, 0);
        drain(cnt);
        chk(cnt == 12, "R6 dropped packets left no bytes", cnt, 12);

        // No avoidance and overflow (R7, R10)
        do_reset();
        region_en = 1'b1;
        for (int k = 0; k < 4; k++) push(32'h1111_1111 * (k + 1), 2'd3);
        chk(!stall_req, "R7 no stall when full", stall_req, 0);
        chk(!overflow, "R10 full but no loss", overflow, 0);
        push(32'h0000_0099, 2'd0);
        chk(overflow && !suppress_pulse, "R10 overflow set", {overflow, suppress_pulse}, 2'b10);
        @(negedge clk); #1;
        chk(overflow, "R10 overflow sticky", overflow, 1);
        pop(b);
        chk(b == 8'h11, "R10 head intact", b, 8'h11);
        wr_level(32'd16);
        chk(!overflow, "R10 cleared by write", overflow, 0);
        drain(cnt);
        chk(cnt == 15, "R10 lost packet not stored", cnt, 15);

        // Both modes on (R8)
        do_reset();
        mode_stall = 1'b1; mode_suppress = 1'b1; region_en = 1'b1;
        push(32'h0000_0001, 2'd0);
        chk(cfg_err && !stall_req && !suppress_pulse, "R8 both modes",
            {cfg_err, stall_req, suppress_pulse}, 3'b100);

        // Ignore variant threshold (R11)
        do_reset();
        mode_stall = 1'b1; region_en = 1'b1;
        wr_level(32'd8);
        push(32'h0000_0001, 2'd0);
        chk(!stall_req, "R11 programmed level 8, free 15", stall_req, 0);
        chk(stall_req_i, "R11 ignore variant acts at capacity", stall_req_i, 1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule